// File: doc/BRIEF.md
# Gigabit Ethernet Idle Ordered-Set Corrector

This block sits in the transmit path of a 1000BASE-X PCS, just before the 8b/10b encoder. Each clock it takes one code group: an eight-bit value plus a flag that marks it as a control (K) or data (D) group. When a K28.5 comma is followed by a data group, the block replaces that data group so that the pair forms a proper idle ordered set. It uses D5.6 (/I1/) when the encoder's running disparity was positive at the comma, and D16.2 (/I2/) when it was negative. Either way, the idle leaves the line at negative disparity.

There are two exemptions. The configuration bytes D21.5 (/C1/) and D2.2 (/C2/) pass through unchanged after a comma. Any control group after a comma is also left alone. Framing characters such as /S/ K27.7, /T/ K29.7, /R/ K23.7 and /V/ K30.7 are never touched. Every output appears exactly one cycle after its input.

The block holds two pieces of state. The first is a two-state machine: `ST_PLAIN` means the last accepted group was not a comma, and `ST_COMMA_SEEN` means it was. Its transitions are:

- `GO_ARM`: `ST_PLAIN` to `ST_COMMA_SEEN` on a valid K28.5.
- `RE_ARM`: `ST_COMMA_SEEN` to `ST_COMMA_SEEN` on a valid K28.5.
- `DISARM`: `ST_COMMA_SEEN` to `ST_PLAIN` on any other valid group.
- `STAY`: no change on a cycle without valid input.

The second is a disparity bit, captured on every valid K28.5.

Top module: `gbe_idle_corrector`

## Requirements
Byte encodings used below are bits 7:5 = y and bits 4:0 = x. K28.5 = 8'hBC with the control flag set (1 = control). D5.6 = 8'hC5, D16.2 = 8'h50, D21.5 = 8'hB5, D2.2 = 8'h42.

- R1: `out_vld` equals `in_vld` of the previous cycle and is 0 during reset.
- R2: A valid data group, other than 8'hB5 or 8'h42, that directly follows a valid K28.5 whose captured disparity was positive (`enc_rd_pos`=1) comes out as 8'hC5.
- R3: Under the same conditions, with negative captured disparity (`enc_rd_pos`=0), the data group comes out as 8'h50.
- R4: Data 8'hB5 or 8'h42 following a K28.5 is output unchanged.
- R5: A control group following a K28.5 is output unchanged. A second K28.5 re-arms the rewrite and captures a fresh disparity.
- R6: Groups that do not directly follow a K28.5 are output unchanged, including K27.7 (8'hFB), K29.7 (8'hFD), K23.7 (8'hF7) and K30.7 (8'hFE).
- R7: Disparity is sampled only in the cycle the K28.5 is accepted. Changes on `enc_rd_pos` afterwards do not affect the rewrite.
- R8: Cycles with `in_vld`=0 neither arm nor clear the comma state. A data group after such a gap still counts as directly following the comma.
- R9: Synchronous active-high reset clears the comma state, so the first data group after reset is not rewritten.
- R10: `out_ctrl` equals the control flag of the previous cycle's input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Input code group valid |
| in_byte | input | 8 | Input code group value |
| in_ctrl | input | 1 | Input is a control group (1) or data (0) |
| enc_rd_pos | input | 1 | Encoder running disparity, 1 = positive |
| out_vld | output | 1 | Output valid, one cycle after input |
| out_byte | output | 8 | Possibly rewritten code group |
| out_ctrl | output | 1 | Control flag of output group |

## Verification
The assertions assume that `in_vld`, `in_byte`, `in_ctrl` and `enc_rd_pos` are driven to known values from the first cycle of reset onward. They also assume that the control flag accurately marks K groups, so an 8'hBC with the flag clear is plain data and not a comma. The stimulus drives every input at the falling edge from the start. Random streams are drawn only from well-formed groups: commas, configuration bytes, framing characters and arbitrary data. Invalid cycles and disparity flips are mixed in so that the gap and sampling rules are exercised.

// File: rtl/gbe_idle_pkg.sv
package gbe_idle_pkg;
    localparam int BYTE_W = 8;
    localparam logic [BYTE_W-1:0] CODE_COMMA = 8'hBC;
    localparam logic [BYTE_W-1:0] CODE_IDLE1 = 8'hC5;
    localparam logic [BYTE_W-1:0] CODE_IDLE2 = 8'h50;
    localparam logic [BYTE_W-1:0] CODE_CFG1  = 8'hB5;
    localparam logic [BYTE_W-1:0] CODE_CFG2  = 8'h42;

    typedef enum logic [0:0] {
        ST_PLAIN      = 1'b0,
        ST_COMMA_SEEN = 1'b1
    } seq_state_t;
endpackage

// File: rtl/idle_code_classify.sv
module idle_code_classify
    import gbe_idle_pkg::*;
(
    input  logic [BYTE_W-1:0] code,
    input  logic              is_ctrl,
    output logic              is_comma,
    output logic              is_cfg
);
    always_comb begin
        is_comma = is_ctrl && (code == CODE_COMMA);
        is_cfg   = !is_ctrl && ((code == CODE_CFG1) || (code == CODE_CFG2));
    end
endmodule

// File: rtl/idle_seq_fsm.sv
module idle_seq_fsm
    import gbe_idle_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic vld,
    input  logic is_comma,
    input  logic rd_pos,
    output logic armed,
    output logic held_pos
);
    seq_state_t state_q, state_d;
    logic       held_q, held_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_PLAIN;
            held_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            held_q  <= held_d;
        end
    end

    always_comb begin
        state_d = state_q;
        held_d  = held_q;
        if (vld) begin
            unique case (state_q)
                ST_PLAIN: begin
                    if (is_comma) begin
                        state_d = ST_COMMA_SEEN;
                        held_d  = rd_pos;
                    end
                end
                ST_COMMA_SEEN: begin
                    if (is_comma) begin
                        state_d = ST_COMMA_SEEN;
                        held_d  = rd_pos;
                    end else begin
                        state_d = ST_PLAIN;
                    end
                end
                default: state_d = ST_PLAIN;
            endcase
        end
    end

    assign armed    = (state_q == ST_COMMA_SEEN);
    assign held_pos = held_q;

    p_gap_holds_r8: assert property (@(posedge clk) disable iff (rst)
        !vld |=> $stable(armed) && $stable(held_pos));
    p_comma_arms_r5: assert property (@(posedge clk) disable iff (rst)
        vld && is_comma |=> armed);
    p_sample_r7: assert property (@(posedge clk) disable iff (rst)
        vld && is_comma |=> held_pos == $past(rd_pos));
endmodule

// File: rtl/gbe_idle_corrector.sv
module gbe_idle_corrector
    import gbe_idle_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              in_ctrl,
    input  logic              enc_rd_pos,
    output logic              out_vld,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_ctrl
);
    logic              is_comma, is_cfg, armed, held_pos, replace;
    logic [BYTE_W-1:0] byte_d;

    idle_code_classify u_classify (
        .code     (in_byte),
        .is_ctrl  (in_ctrl),
        .is_comma (is_comma),
        .is_cfg   (is_cfg)
    );

    idle_seq_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .vld      (in_vld),
        .is_comma (is_comma),
        .rd_pos   (enc_rd_pos),
        .armed    (armed),
        .held_pos (held_pos)
    );

    always_comb begin
        replace = armed && in_vld && !in_ctrl && !is_cfg;
        byte_d  = in_byte;
        if (replace) byte_d = held_pos ? CODE_IDLE1 : CODE_IDLE2;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld  <= 1'b0;
            out_byte <= '0;
            out_ctrl <= 1'b0;
        end else begin
            out_vld  <= in_vld;
            out_byte <= byte_d;
            out_ctrl <= in_ctrl;
        end
    end

    p_vld_delay_r1: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);
    p_vld_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld);
    p_ctrl_flag_r10: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_ctrl == $past(in_ctrl));
    p_idle1_r2: assert property (@(posedge clk) disable iff (rst)
        in_vld && armed && held_pos && !in_ctrl && !is_cfg |=> out_byte == CODE_IDLE1);
    p_idle2_r3: assert property (@(posedge clk) disable iff (rst)
        in_vld && armed && !held_pos && !in_ctrl && !is_cfg |=> out_byte == CODE_IDLE2);
    p_cfg_pass_r4: assert property (@(posedge clk) disable iff (rst)
        in_vld && is_cfg |=> out_byte == $past(in_byte));
    p_ctrl_pass_r5: assert property (@(posedge clk) disable iff (rst)
        in_vld && in_ctrl |=> out_byte == $past(in_byte));
    p_plain_pass_r6: assert property (@(posedge clk) disable iff (rst)
        in_vld && !armed |=> out_byte == $past(in_byte));
endmodule

// File: tb/gbe_idle_corrector_bench.sv
module gbe_idle_corrector_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_vld = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_ctrl = 1'b0;
    logic       enc_rd_pos = 1'b0;
    logic       out_vld;
    logic [7:0] out_byte;
    logic       out_ctrl;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    gbe_idle_corrector u_gbe_idle_corrector (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_byte(in_byte),
        .in_ctrl(in_ctrl), .enc_rd_pos(enc_rd_pos),
        .out_vld(out_vld), .out_byte(out_byte), .out_ctrl(out_ctrl)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    int    m_armed = 0, m_held = 0, m_gap = 0, m_fresh = 1;
    int    e_vld = 0, e_byte = 0, e_ctrl = 0;
    string e_tag = "R9";

    always @(posedge clk) begin
        if (rst) begin
            e_vld = 0; e_byte = 0; e_ctrl = 0;
            m_armed = 0; m_held = 0; m_gap = 0; m_fresh = 1;
            e_tag = "R9";
        end else begin
            e_vld  = in_vld;
            e_ctrl = in_ctrl;
            e_byte = in_byte;
            e_tag  = "R6";
            if (in_vld) begin
                if (m_armed != 0) begin
                    if (in_ctrl) e_tag = "R5";
                    else if (in_byte == 8'hB5 || in_byte == 8'h42) e_tag = "R4";
                    else begin
                        e_byte = (m_held != 0) ? 8'hC5 : 8'h50;
                        e_tag  = (m_held != 0) ? "R2" : "R3";
                        if (m_held != int'(enc_rd_pos)) e_tag = {e_tag, "+R7"};
                    end
                    if (m_gap != 0) e_tag = {e_tag, "+R8"};
                end else if (m_fresh != 0) e_tag = "R9";
                m_fresh = 0;
                m_gap   = 0;
                if (in_ctrl && in_byte == 8'hBC) begin
                    m_armed = 1; m_held = enc_rd_pos;
                end else m_armed = 0;
            end else if (m_armed != 0) m_gap = 1;
        end
    end

    task automatic compare();
        n_cmp++;
        if (out_vld !== e_vld[0]) begin
            n_bad++;
            $display("FAIL R1 out_vld act=%0b exp=%0d", out_vld, e_vld);
        end else if (e_vld != 0 && out_ctrl !== e_ctrl[0]) begin
            n_bad++;
            $display("FAIL R10 out_ctrl act=%0b exp=%0d", out_ctrl, e_ctrl);
        end else if (e_vld != 0 && out_byte !== e_byte[7:0]) begin
            n_bad++;
            $display("FAIL %s out_byte act=%02h exp=%02h", e_tag, out_byte, e_byte[7:0]);
        end
    endtask

    task automatic step(input bit v, input logic [7:0] b, input bit k, input bit rd);
        @(negedge clk);
        compare();
        in_vld = v; in_byte = b; in_ctrl = k; enc_rd_pos = rd;
    endtask

    task automatic flush();
        step(0, 8'h00, 0, enc_rd_pos);
        step(0, 8'h00, 0, enc_rd_pos);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        compare();                       // R1/R9: reset state, out_vld low
        @(negedge clk); rst = 1'b0;
        // R9: data first after reset is untouched
        step(1, 8'hC3, 0, 1);
        // R2 and R3: comma then data with each disparity
        step(1, 8'hBC, 1, 1); step(1, 8'h6E, 0, 1);   // D14.3
        step(1, 8'hBC, 1, 0); step(1, 8'h18, 0, 0);   // D24.0
        step(1, 8'hBC, 1, 1); step(1, 8'h0F, 0, 0);   // R7: rd flips after comma
        // R4: configuration sets
        step(1, 8'hBC, 1, 1); step(1, 8'hB5, 0, 1);
        step(1, 8'hBC, 1, 0); step(1, 8'h42, 0, 0);
        // R5: back-to-back commas, comma then other K
        step(1, 8'hBC, 1, 1); step(1, 8'hBC, 1, 0); step(1, 8'h11, 0, 1);
        step(1, 8'hBC, 1, 0); step(1, 8'hFB, 1, 0); step(1, 8'h22, 0, 0);
        // R6: framing characters and plain data
        step(1, 8'hFD, 1, 0); step(1, 8'hF7, 1, 1); step(1, 8'hFE, 1, 0);
        step(1, 8'hBC, 0, 1); step(1, 8'h33, 0, 1);   // D28.5 is not a comma
        // R8: gap between comma and data
        step(1, 8'hBC, 1, 1); step(0, 8'hBC, 1, 0); step(0, 8'h77, 0, 0);
        step(1, 8'h77, 0, 0);
        // R9: reset clears armed state
        step(1, 8'hBC, 1, 1);
        @(negedge clk); compare(); rst = 1'b1; in_vld = 1'b0;
        @(negedge clk); rst = 1'b0;
        step(1, 8'h5A, 0, 1);
        flush();
        // random streams
        for (int i = 0; i < 4000; i++) begin
            int sel = $urandom_range(0, 15);
            bit v   = ($urandom_range(0, 7) != 0);
            bit rd  = $urandom_range(0, 1);
            case (sel)
                0, 1, 2, 3, 4: step(v, 8'hBC, 1, rd);
                5:  step(v, 8'hB5, 0, rd);
                6:  step(v, 8'h42, 0, rd);
                7:  step(v, 8'hFB, 1, rd);
                8:  step(v, 8'hFD, 1, rd);
                9:  step(v, 8'hF7, 1, rd);
                10: step(v, 8'hFE, 1, rd);
                default: step(v, 8'($urandom), 0, rd);
            endcase
        end
        flush();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog act=hung exp=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule